// File: doc/BRIEF.md
# Address Range Access Watchpoint Bank

This block watches the stream of memory accesses that a memory arbiter has granted and reports accesses that fall inside watched windows. It holds a bank of identical watch units (four by default). Each unit is given a lowest and a highest watched address, a mask of access kinds and a mask of requesting clients. An access trips a unit only when all three agree. A unit that trips records the access: the matching clients, the address, the kind of access, the lowest matching client and the transfer size. It also sets its status bit.

The recorded values stay frozen until software acknowledges that unit. A shared interrupt section holds one enable bit per unit. It drives a single interrupt line from the enabled status bits. It also offers a write-one-to-clear acknowledge register that covers all units. Software reaches all state through a plain register port: a write strobe with address and data, and a combinational read data bus.

Top module: `acc_watch_bank`

## Requirements
- R1: A unit trips only if the access address A satisfies low <= A <= high, so both window ends are included.
- R2: The access-kind mask has bit 0 for reads (acc_write=0) and bit 1 for writes (acc_write=1). An access whose kind bit is clear never trips the unit.
- R3: An access carries a client bit vector. It trips a unit only if that vector ANDed with the unit's client mask is nonzero. The recorded client set is that AND.
- R4: On a trip the unit records the address and the kind (value 1 = read, 2 = write). It also records the lowest client index in the recorded client set and the size. Information offset 7 packs the client index in bits [7:0] and the size in bits [15:8].
- R5: While a unit's status is set and no acknowledge arrives, further trips leave every recorded value unchanged.
- R6: A write to global offset 1 clears the status of each unit whose data bit is 1. Units whose data bit is 0 keep their status.
- R7: A write of any data to a unit's offset 4 clears that unit's status only.
- R8: The global offset 0 register holds one interrupt enable bit per unit. Global offset 2 reads the enabled status. irq is 1 exactly when some unit has both status and enable set.
- R9: An acknowledge and a trip that arrive in the same cycle leave the status set, and the new access is recorded.
- R10: Units are independent: one access can trip several units in the same cycle.
- R11: reg_addr = {selector, offset[2:0]}. Selector i < NUM_UNITS picks unit i: offset 0 low, 1 high, 2 kind mask, 3 client mask (all read/write); 4 recorded clients; 5 recorded address; 6 recorded kind. Selector NUM_UNITS picks the global registers; offset 1 reads the raw status.
- R12: After reset all status, enables and configuration read as zero, and no access trips any unit.
- R13: A status bit is set one clock edge after the access cycle. From that point it is visible at the ports, including irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | A granted access is present this cycle |
| acc_addr | input | ADDR_W | Access address |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_clients | input | CLIENT_W | Bit vector of requesting clients |
| acc_size | input | SIZE_W | Transfer size of the access |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register address {selector, offset} |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Combinational register read data |
| irq | output | 1 | Combined enabled interrupt |

## Verification
On every cycle, the assertions check four things in each unit. A trip always sets status on the next edge. A newly raised status always holds an address inside the window that was in force. Recorded values stay still while status is held without acknowledge. An acknowledge without a trip always clears status. They also check that irq never rises with no status set. The bench scenarios are needed for the rest. These are the exact window boundaries, the kind and client mask filtering, and the lowest-client and size packing. They also cover write-zero acknowledges, overlapping windows, and the acknowledge-with-trip race, which need chosen values to show the right numbers.

// File: rtl/awp_pkg.sv
package awp_pkg;
   // Offsets inside one unit's register window
   localparam logic [2:0] OFF_LO      = 3'd0;
   localparam logic [2:0] OFF_HI      = 3'd1;
   localparam logic [2:0] OFF_KIND    = 3'd2;
   localparam logic [2:0] OFF_CMASK   = 3'd3;
   localparam logic [2:0] OFF_HITCLI  = 3'd4;  // read: recorded clients, write: acknowledge
   localparam logic [2:0] OFF_HITADR  = 3'd5;
   localparam logic [2:0] OFF_HITKIND = 3'd6;
   localparam logic [2:0] OFF_HITINFO = 3'd7;
   // Offsets inside the global window
   localparam logic [2:0] GOFF_ENABLE = 3'd0;
   localparam logic [2:0] GOFF_STATUS = 3'd1;
   localparam logic [2:0] GOFF_MASKED = 3'd2;
   // Recorded kind encoding
   localparam logic [1:0] KIND_RD = 2'b01;
   localparam logic [1:0] KIND_WR = 2'b10;
endpackage

// File: rtl/awp_unit.sv
module awp_unit
   import awp_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int CLIENT_W = 14,
   parameter int SIZE_W   = 4,
   parameter int DATA_W   = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [2:0]          cfg_off,
   input  logic [DATA_W-1:0]   cfg_wdata,
   input  logic                ack_i,
   input  logic                acc_valid_i,
   input  logic [ADDR_W-1:0]   acc_addr_i,
   input  logic                acc_write_i,
   input  logic [CLIENT_W-1:0] acc_clients_i,
   input  logic [SIZE_W-1:0]   acc_size_i,
   output logic                status_o,
   output logic [DATA_W-1:0]   rd_data_o
);
   localparam int CIDX_W = $clog2(CLIENT_W);

   logic [ADDR_W-1:0]   lo_q, hi_q;
   logic [1:0]          kind_q;
   logic [CLIENT_W-1:0] cmask_q;

   logic                status_q;
   logic [CLIENT_W-1:0] cap_cli_q;
   logic [ADDR_W-1:0]   cap_addr_q;
   logic [1:0]          cap_kind_q;
   logic [SIZE_W-1:0]   cap_size_q;
   logic [CIDX_W-1:0]   cap_first_q;

   function automatic logic [CIDX_W-1:0] lowest_set(input logic [CLIENT_W-1:0] v);
      logic [CIDX_W-1:0] idx;
      idx = '0;
      for (int i = CLIENT_W - 1; i >= 0; i--) begin
         if (v[i]) idx = CIDX_W'(i);
      end
      return idx;
   endfunction

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q    <= '0;
         hi_q    <= '0;
         kind_q  <= '0;
         cmask_q <= '0;
      end else if (cfg_we) begin
         case (cfg_off)
            OFF_LO:    lo_q    <= cfg_wdata[ADDR_W-1:0];
            OFF_HI:    hi_q    <= cfg_wdata[ADDR_W-1:0];
            OFF_KIND:  kind_q  <= cfg_wdata[1:0];
            OFF_CMASK: cmask_q <= cfg_wdata[CLIENT_W-1:0];
            default: ;
         endcase
      end
   end

   // match logic
   logic                in_window, kind_ok, hit, take;
   logic [CLIENT_W-1:0] matched;

   always_comb begin
      in_window = (acc_addr_i >= lo_q) && (acc_addr_i <= hi_q);
      kind_ok   = acc_write_i ? kind_q[1] : kind_q[0];
      matched   = acc_clients_i & cmask_q;
      hit       = acc_valid_i && in_window && kind_ok && (|matched);
      take      = hit && (!status_q || ack_i);
   end

   // status and capture
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q    <= 1'b0;
         cap_cli_q   <= '0;
         cap_addr_q  <= '0;
         cap_kind_q  <= '0;
         cap_size_q  <= '0;
         cap_first_q <= '0;
      end else begin
         status_q <= hit || (status_q && !ack_i);
         if (take) begin
            cap_cli_q   <= matched;
            cap_addr_q  <= acc_addr_i;
            cap_kind_q  <= acc_write_i ? KIND_WR : KIND_RD;
            cap_size_q  <= acc_size_i;
            cap_first_q <= lowest_set(matched);
         end
      end
   end

   assign status_o = status_q;

   // readback
   always_comb begin
      rd_data_o = '0;
      case (cfg_off)
         OFF_LO:      rd_data_o = DATA_W'(lo_q);
         OFF_HI:      rd_data_o = DATA_W'(hi_q);
         OFF_KIND:    rd_data_o = DATA_W'(kind_q);
         OFF_CMASK:   rd_data_o = DATA_W'(cmask_q);
         OFF_HITCLI:  rd_data_o = DATA_W'(cap_cli_q);
         OFF_HITADR:  rd_data_o = DATA_W'(cap_addr_q);
         OFF_HITKIND: rd_data_o = DATA_W'(cap_kind_q);
         default: begin
            rd_data_o[CIDX_W-1:0]  = cap_first_q;
            rd_data_o[8 +: SIZE_W] = cap_size_q;
         end
      endcase
   end

   // checks next to the logic they guard
   assert_trip_sets_R13: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> status_o);

   assert_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_q) |-> (cap_addr_q >= $past(lo_q)) && (cap_addr_q <= $past(hi_q)));

   assert_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q && !ack_i) |=> ($stable(cap_addr_q) && $stable(cap_cli_q)
                                && $stable(cap_size_q) && $stable(cap_kind_q)));

   assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !hit) |=> !status_o);

   assert_race_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && hit) |=> (status_o && cap_addr_q == $past(acc_addr_i)));
endmodule

// File: rtl/awp_irq.sv
module awp_irq #(
   parameter int NUM_UNITS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en_we,
   input  logic [NUM_UNITS-1:0] en_wdata,
   input  logic [NUM_UNITS-1:0] status_i,
   output logic [NUM_UNITS-1:0] enable_o,
   output logic [NUM_UNITS-1:0] masked_o,
   output logic                 irq_o
);
   logic [NUM_UNITS-1:0] en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= '0;
      else if (en_we) en_q <= en_wdata;
   end

   assign enable_o = en_q;
   assign masked_o = status_i & en_q;
   assign irq_o    = |masked_o;

   assert_irq_needs_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ($countones(status_i) > 0));

   assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ($countones(en_q) > 0));
endmodule

// File: rtl/acc_watch_bank.sv
module acc_watch_bank
   import awp_pkg::*;
#(
   parameter int NUM_UNITS = 4,
   parameter int ADDR_W    = 32,
   parameter int CLIENT_W  = 14,
   parameter int SIZE_W    = 4,
   parameter int DATA_W    = 32,
   parameter int REG_AW    = $clog2(NUM_UNITS + 1) + 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                acc_valid,
   input  logic [ADDR_W-1:0]   acc_addr,
   input  logic                acc_write,
   input  logic [CLIENT_W-1:0] acc_clients,
   input  logic [SIZE_W-1:0]   acc_size,
   input  logic                reg_we,
   input  logic [REG_AW-1:0]   reg_addr,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   output logic                irq
);
   localparam int SEL_W = REG_AW - 3;

   // elaboration-time parameter checks
   if (NUM_UNITS < 1)                  $error("NUM_UNITS must be at least 1");
   if (CLIENT_W < 2)                   $error("CLIENT_W must be at least 2");
   if ($clog2(CLIENT_W) > 8)           $error("client index must fit in 8 bits");
   if (SIZE_W < 1 || SIZE_W > 8)       $error("SIZE_W must be 1..8");
   if (DATA_W < ADDR_W)                $error("DATA_W must hold an address");
   if (DATA_W < CLIENT_W)              $error("DATA_W must hold a client mask");
   if (DATA_W < 16)                    $error("DATA_W must be at least 16");
   if (DATA_W < NUM_UNITS)             $error("DATA_W must hold one bit per unit");
   if (REG_AW < $clog2(NUM_UNITS + 1) + 3) $error("REG_AW too narrow for the unit selector");

   logic [SEL_W-1:0] sel;
   logic [2:0]       off;
   logic             glob_sel;

   assign sel      = reg_addr[REG_AW-1:3];
   assign off      = reg_addr[2:0];
   assign glob_sel = (sel == SEL_W'(NUM_UNITS));

   logic [NUM_UNITS-1:0] status, enable, masked;
   logic [DATA_W-1:0]    unit_rd [NUM_UNITS];

   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
      logic unit_we, unit_ack;
      assign unit_we  = reg_we && (sel == SEL_W'(u));
      assign unit_ack = (unit_we && off == OFF_HITCLI)
                        || (reg_we && glob_sel && off == GOFF_STATUS && reg_wdata[u]);

      awp_unit #(
         .ADDR_W  (ADDR_W),
         .CLIENT_W(CLIENT_W),
         .SIZE_W  (SIZE_W),
         .DATA_W  (DATA_W)
      ) u_unit (
         .clk          (clk),
         .rst_n        (rst_n),
         .cfg_we       (unit_we),
         .cfg_off      (off),
         .cfg_wdata    (reg_wdata),
         .ack_i        (unit_ack),
         .acc_valid_i  (acc_valid),
         .acc_addr_i   (acc_addr),
         .acc_write_i  (acc_write),
         .acc_clients_i(acc_clients),
         .acc_size_i   (acc_size),
         .status_o     (status[u]),
         .rd_data_o    (unit_rd[u])
      );
   end

   awp_irq #(.NUM_UNITS(NUM_UNITS)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_we   (reg_we && glob_sel && off == GOFF_ENABLE),
      .en_wdata(reg_wdata[NUM_UNITS-1:0]),
      .status_i(status),
      .enable_o(enable),
      .masked_o(masked),
      .irq_o   (irq)
   );

   always_comb begin
      reg_rdata = '0;
      if (glob_sel) begin
         case (off)
            GOFF_ENABLE: reg_rdata = DATA_W'(enable);
            GOFF_STATUS: reg_rdata = DATA_W'(status);
            GOFF_MASKED: reg_rdata = DATA_W'(masked);
            default:     reg_rdata = '0;
         endcase
      end else begin
         for (int u = 0; u < NUM_UNITS; u++) begin
            if (sel == SEL_W'(u)) reg_rdata = unit_rd[u];
         end
      end
   end

   assert_ack_global_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && glob_sel && off == GOFF_STATUS && !acc_valid)
      |=> ((status & $past(reg_wdata[NUM_UNITS-1:0])) == '0));
endmodule

// File: tb/acc_watch_bank_bench.sv
module acc_watch_bank_bench;
   localparam int CLK_PERIOD = 10;
   localparam int GBASE = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic        acc_write = 1'b0;
   logic [13:0] acc_clients = '0;
   logic [3:0]  acc_size = '0;
   logic        reg_we = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   acc_watch_bank u_acc_watch_bank (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
      .acc_write(acc_write), .acc_clients(acc_clients), .acc_size(acc_size),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 6'(a); reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      reg_addr = 6'(a);
      #1;
      d = reg_rdata;
   endtask

   task automatic access(input logic [31:0] a, input logic w, input logic [13:0] c,
                         input logic [3:0] s);
      @(negedge clk);
      acc_valid = 1'b1; acc_addr = a; acc_write = w; acc_clients = c; acc_size = s;
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   task automatic expect_reg(input string req, input int a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      check(req, v, exp);
   endtask

   task automatic t_reset();
      check("R12 irq after reset", {31'd0, irq}, 32'd0);
      expect_reg("R12 status after reset", GBASE + 1, 32'd0);
      expect_reg("R12 low after reset", 0, 32'd0);
      expect_reg("R12 enable after reset", GBASE + 0, 32'd0);
      access(32'h0, 1'b0, 14'h0001, 4'd1);
      expect_reg("R12 no trip when unconfigured", GBASE + 1, 32'd0);
   endtask

   task automatic t_config();
      wr(0*8+0, 32'h100);  wr(0*8+1, 32'h1FF);  wr(0*8+2, 3);  wr(0*8+3, 32'h3FFF);
      wr(1*8+0, 32'h1000); wr(1*8+1, 32'h1FFF); wr(1*8+2, 2);  wr(1*8+3, 32'h3FFF);
      wr(2*8+0, 32'h0);    wr(2*8+1, 32'hFFFF_FFFF); wr(2*8+2, 3); wr(2*8+3, 32'h0034);
      wr(3*8+0, 32'h180);  wr(3*8+1, 32'h280);  wr(3*8+2, 1);  wr(3*8+3, 32'h3FFF);
      expect_reg("R11 unit1 high readback", 1*8+1, 32'h1FFF);
      expect_reg("R11 unit2 client mask readback", 2*8+3, 32'h0034);
      expect_reg("R11 unit3 kind readback", 3*8+2, 32'h1);
   endtask

   task automatic t_window();
      access(32'h0FF, 1'b1, 14'h0001, 4'd1);
      expect_reg("R1 below low end", GBASE + 1, 32'd0);
      access(32'h200, 1'b1, 14'h0001, 4'd1);
      expect_reg("R1 above high end", GBASE + 1, 32'd0);
      access(32'h100, 1'b1, 14'h0001, 4'd1);
      expect_reg("R1 R13 low end included", GBASE + 1, 32'h1);
      wr(GBASE + 1, 32'h1);
      access(32'h1FF, 1'b1, 14'h0001, 4'd1);
      expect_reg("R1 high end included", GBASE + 1, 32'h1);
      expect_reg("R1 recorded address", 0*8+5, 32'h1FF);
      wr(GBASE + 1, 32'hF);
   endtask

   task automatic t_kind();
      access(32'h1800, 1'b0, 14'h0001, 4'd1);
      expect_reg("R2 read filtered by kind mask", GBASE + 1, 32'd0);
      access(32'h1800, 1'b1, 14'h0001, 4'd1);
      expect_reg("R2 write trips", GBASE + 1, 32'h2);
      expect_reg("R4 recorded kind write", 1*8+6, 32'h2);
      wr(GBASE + 1, 32'h2);
   endtask

   task automatic t_clients();
      access(32'h5000, 1'b0, 14'h0003, 4'd3);
      expect_reg("R3 no client overlap", GBASE + 1, 32'd0);
      access(32'h5000, 1'b0, 14'h0036, 4'd5);
      expect_reg("R3 overlap trips", GBASE + 1, 32'h4);
      expect_reg("R3 recorded client set", 2*8+4, 32'h0034);
      expect_reg("R4 recorded address", 2*8+5, 32'h5000);
      expect_reg("R4 recorded kind read", 2*8+6, 32'h1);
      expect_reg("R4 lowest client and size", 2*8+7, 32'h0502);
   endtask

   task automatic t_frozen();
      access(32'h6000, 1'b1, 14'h0010, 4'd7);
      expect_reg("R5 status held", GBASE + 1, 32'h4);
      expect_reg("R5 address frozen", 2*8+5, 32'h5000);
      expect_reg("R5 info frozen", 2*8+7, 32'h0502);
      expect_reg("R5 clients frozen", 2*8+4, 32'h0034);
   endtask

   task automatic t_acks();
      wr(GBASE + 1, 32'h0);
      expect_reg("R6 zero write keeps status", GBASE + 1, 32'h4);
      wr(2*8+4, 32'h0);
      expect_reg("R7 per-unit ack clears", GBASE + 1, 32'h0);
   endtask

   task automatic t_irq();
      access(32'h150, 1'b1, 14'h0001, 4'd1);
      check("R8 irq off while disabled", {31'd0, irq}, 32'd0);
      expect_reg("R8 raw status set", GBASE + 1, 32'h1);
      wr(GBASE + 0, 32'h1);
      check("R8 irq on when enabled", {31'd0, irq}, 32'd1);
      expect_reg("R8 masked status", GBASE + 2, 32'h1);
      wr(GBASE + 0, 32'hE);
      check("R8 irq off with other enables", {31'd0, irq}, 32'd0);
      wr(GBASE + 0, 32'hF);
      check("R8 R13 irq on again", {31'd0, irq}, 32'd1);
   endtask

   task automatic t_race();
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 6'(GBASE + 1); reg_wdata = 32'h1;
      acc_valid = 1'b1; acc_addr = 32'h1A0; acc_write = 1'b1; acc_clients = 14'h0002;
      acc_size = 4'd2;
      @(negedge clk);
      reg_we = 1'b0; acc_valid = 1'b0;
      expect_reg("R9 status kept on ack plus trip", GBASE + 1, 32'h1);
      expect_reg("R9 new access recorded", 0*8+5, 32'h1A0);
      expect_reg("R9 new info recorded", 0*8+7, 32'h0201);
      wr(GBASE + 1, 32'hF);
      expect_reg("R6 global ack clears all", GBASE + 1, 32'h0);
      check("R6 irq cleared", {31'd0, irq}, 32'd0);
   endtask

   task automatic t_overlap();
      access(32'h1C0, 1'b0, 14'h0001, 4'd1);
      expect_reg("R10 two units trip", GBASE + 1, 32'h9);
      expect_reg("R10 unit3 address", 3*8+5, 32'h1C0);
      expect_reg("R10 unit0 address", 0*8+5, 32'h1C0);
      wr(GBASE + 1, 32'h8);
      expect_reg("R6 only selected bit cleared", GBASE + 1, 32'h1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_config();
      t_window();
      t_kind();
      t_clients();
      t_frozen();
      t_acks();
      t_irq();
      t_race();
      t_overlap();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule